// File: doc/BRIEF.md
# Burst-Mode and PFC Supply Gate Controller

This block sits beside the switching-cycle sequencer of a quasi-resonant flyback controller. It decides when the converter must stop issuing pulses and enter burst operation, and when the power-factor front stage should lose its supply. All inputs are flags that are already synchronised to `clk`: a feedback-at-skip-level flag, a feedback-above-hysteresis release flag, a standby comparator flag, the two mains sense flags (under the low threshold, above the high threshold), and the fault and latched-fault flags.

When feedback falls to the skip level, the block raises a skip request that holds off pulses. It holds that request until the release flag arrives. Each time a burst ends this way, a one-cycle restart pulse is issued and a short soft-start window follows, so that the peak current envelope ramps up rather than stepping. The front-stage supply switch enable drops only after the standby flag has stayed high for a confirmation window. It comes back in the same cycle that standby clears. The enable is also forced low during faults, latched faults and brown-out. Every pin is a plain level or pulse. No data stream passes through the block, so it has no handshake and no back-pressure.

Top module: `skip_standby_gate`

## Requirements
- R1: After a rising clock edge that samples `skip_low_i` high, `skip_req_o` is 1. `skip_low_i` wins over `skip_release_i` when both are high.
- R2: `skip_req_o` keeps its value across every edge that samples both `skip_low_i` and `skip_release_i` low. It clears after an edge that samples `skip_release_i` high and `skip_low_i` low.
- R3: `ss_restart_o` is 1 for exactly the one cycle that follows the edge on which `skip_req_o` went from 1 to 0. It is 0 at all other times.
- R4: `ss_active_o` rises on the edge that follows a restart pulse and stays high for exactly `SS_CYCLES` cycles. A new restart pulse during the window reloads it to the full length.
- R5: Brown-out is active out of reset. An edge that samples `bo_low_i` high sets it, and this input wins over `bo_high_i`. An edge that samples only `bo_high_i` high clears it. Otherwise it holds its value.
- R6: `pulse_inhibit_o` is 1 exactly when a skip request is pending or brown-out is active.
- R7: `pfc_sw_en_o` goes low only once `stby_i` has been sampled high on `CONFIRM_CYCLES` consecutive edges. It stays low while `stby_i` remains high.
- R8: An edge that samples `stby_i` low restarts the confirmation count from zero. Any later entry into standby again needs the full `CONFIRM_CYCLES` edges.
- R9: When `stby_i` falls, `pfc_sw_en_o` returns high in the same cycle, without waiting for a clock edge, provided no fault, latched fault or brown-out is present.
- R10: `pfc_sw_en_o` is 0 in any cycle where `fault_i` or `latched_fault_i` is high, or where brown-out is active.
- R11: While `rst_n` is low: `skip_req_o`, `ss_restart_o` and `ss_active_o` are 0, `pulse_inhibit_o` is 1 and `pfc_sw_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| skip_low_i | input | 1 | Feedback has fallen to the skip level |
| skip_release_i | input | 1 | Feedback is above the skip level plus hysteresis |
| stby_i | input | 1 | Standby comparator flag |
| bo_low_i | input | 1 | Mains sense is below the lower threshold |
| bo_high_i | input | 1 | Mains sense is above the upper threshold |
| fault_i | input | 1 | Recoverable fault present |
| latched_fault_i | input | 1 | Latched fault present |
| skip_req_o | output | 1 | Hold pulses off (burst gap) |
| ss_restart_o | output | 1 | One-cycle soft-start restart pulse |
| ss_active_o | output | 1 | Soft-start window in progress |
| pulse_inhibit_o | output | 1 | Pulses blocked by skip or brown-out |
| pfc_sw_en_o | output | 1 | Front-stage supply switch enable (1 = closed) |

## Verification
The embedded properties check on every cycle how the skip request sets and holds, that a restart pulse is never two cycles wide, that the soft-start window opens after each pulse, that brown-out clears on the upper flag, and that a fault always opens the supply switch. The exact confirmation length, the zeroing of a partly counted standby spell, the exact soft-start window length and its reload, and the same-cycle return of the switch when standby clears are shown only by the bench's scenarios. Those scenarios include short standby spells one edge below the limit and restart pulses issued inside a running window, and the bench compares every output each clock against its own behavioural model.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic {
    SK_RUN  = 1'b0,
    SK_HOLD = 1'b1
  } skip_state_e;
endpackage

// File: rtl/sg_skip_ctl.sv
module sg_skip_ctl
  import sg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic skip_low_i,
  input  logic skip_release_i,
  output logic skip_req_o,
  output logic restart_o
);
  skip_state_e state_q, state_d;
  logic        restart_q;

  always_comb begin
    state_d = state_q;
    if (skip_low_i)            state_d = SK_HOLD;
    else if (skip_release_i)   state_d = SK_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SK_RUN;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= (state_q == SK_HOLD) && (state_d == SK_RUN);
    end
  end

  assign skip_req_o = (state_q == SK_HOLD);
  assign restart_o  = restart_q;

  assert_skip_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    skip_low_i |=> skip_req_o);
  assert_skip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip_low_i && !skip_release_i) |=> $stable(skip_req_o));
  assert_restart_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);
endmodule

// File: rtl/sg_softstart.sv
module sg_softstart #(
  parameter int SS_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic active_o
);
  localparam int SW = $clog2(SS_CYCLES + 1);
  localparam logic [SW-1:0] LOAD = SW'(SS_CYCLES);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_ramp_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> active_o);
endmodule

// File: rtl/sg_brownout.sv
module sg_brownout (
  input  logic clk,
  input  logic rst_n,
  input  logic low_i,
  input  logic high_i,
  output logic active_o
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= 1'b1;
    else if (low_i)   act_q <= 1'b1;
    else if (high_i)  act_q <= 1'b0;
  end

  assign active_o = act_q;

  assert_bo_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (high_i && !low_i) |=> !active_o);
  assert_bo_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    low_i |=> active_o);
endmodule

// File: rtl/sg_stby_confirm.sv
module sg_stby_confirm #(
  parameter int CONFIRM_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_i,
  output logic confirmed_o
);
  localparam int CW = $clog2(CONFIRM_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CONFIRM_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          conf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      conf_q <= 1'b0;
    end else if (!stby_i) begin
      cnt_q  <= '0;
      conf_q <= 1'b0;
    end else if (!conf_q) begin
      if (cnt_q == LAST) conf_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign confirmed_o = conf_q;

  assert_confirm_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_i |=> !confirmed_o);
  assert_confirm_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (confirmed_o && stby_i) |=> confirmed_o);
endmodule

// File: rtl/skip_standby_gate.sv
module skip_standby_gate #(
  parameter int CONFIRM_CYCLES = 4000,
  parameter int SS_CYCLES      = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic skip_low_i,
  input  logic skip_release_i,
  input  logic stby_i,
  input  logic bo_low_i,
  input  logic bo_high_i,
  input  logic fault_i,
  input  logic latched_fault_i,
  output logic skip_req_o,
  output logic ss_restart_o,
  output logic ss_active_o,
  output logic pulse_inhibit_o,
  output logic pfc_sw_en_o
);
  logic skip_req, restart, bo_act, stby_conf;

  sg_skip_ctl u_skip (
    .clk            (clk),
    .rst_n          (rst_n),
    .skip_low_i     (skip_low_i),
    .skip_release_i (skip_release_i),
    .skip_req_o     (skip_req),
    .restart_o      (restart)
  );

  sg_softstart #(.SS_CYCLES(SS_CYCLES)) u_ss (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .active_o  (ss_active_o)
  );

  sg_brownout u_bo (
    .clk      (clk),
    .rst_n    (rst_n),
    .low_i    (bo_low_i),
    .high_i   (bo_high_i),
    .active_o (bo_act)
  );

  sg_stby_confirm #(.CONFIRM_CYCLES(CONFIRM_CYCLES)) u_stby (
    .clk         (clk),
    .rst_n       (rst_n),
    .stby_i      (stby_i),
    .confirmed_o (stby_conf)
  );

  assign skip_req_o      = skip_req;
  assign ss_restart_o    = restart;
  assign pulse_inhibit_o = skip_req | bo_act;
  assign pfc_sw_en_o     = !(stby_conf && stby_i) && !bo_act && !fault_i && !latched_fault_i;

  assert_fault_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i || latched_fault_i || bo_act) |-> !pfc_sw_en_o);
  assert_exit_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_i && !fault_i && !latched_fault_i && !bo_act) |-> pfc_sw_en_o);
  assert_inhibit_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req_o |-> pulse_inhibit_o);
endmodule

// File: tb/skip_standby_gate_test.sv
module skip_standby_gate_test;
  localparam int CONF = 20;
  localparam int SS   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic skip_low = 0, skip_rel = 0, stby = 0, bo_low = 0, bo_high = 0, flt = 0, lflt = 0;
  logic skip_req, ss_restart, ss_active, inhibit, pfc_en;

  int checks = 0;
  int errors = 0;
  int m_skip = 0, m_restart = 0, m_ss = 0, m_bo = 1, m_run = 0;
  int lcg = 12345;

  always #2.5 clk = ~clk;

  skip_standby_gate #(.CONFIRM_CYCLES(CONF), .SS_CYCLES(SS)) uut (
    .clk(clk), .rst_n(rst_n), .skip_low_i(skip_low), .skip_release_i(skip_rel),
    .stby_i(stby), .bo_low_i(bo_low), .bo_high_i(bo_high), .fault_i(flt),
    .latched_fault_i(lflt), .skip_req_o(skip_req), .ss_restart_o(ss_restart),
    .ss_active_o(ss_active), .pulse_inhibit_o(inhibit), .pfc_sw_en_o(pfc_en)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic e_pfc;
    e_pfc = !((m_run >= CONF) && stby) && (m_bo == 0) && !flt && !lflt;
    check(skip_req,   m_skip != 0,                 "R1/R2 skip_req");
    check(ss_restart, m_restart != 0,              "R3 ss_restart");
    check(ss_active,  m_ss > 0,                    "R4 ss_active");
    check(inhibit,    (m_skip != 0) || (m_bo != 0), "R6 pulse_inhibit (R5 brown-out)");
    check(pfc_en,     e_pfc,                       "R7/R8/R9/R10 pfc_sw_en");
  endtask

  task automatic step(input logic sl, input logic sr, input logic sb,
                      input logic bl, input logic bh, input logic f, input logic lf);
    int prev;
    @(negedge clk);
    skip_low = sl; skip_rel = sr; stby = sb; bo_low = bl; bo_high = bh; flt = f; lflt = lf;
    @(posedge clk);
    #1;
    if (m_restart != 0) m_ss = SS;
    else if (m_ss > 0)  m_ss = m_ss - 1;
    prev = m_skip;
    if (sl)      m_skip = 1;
    else if (sr) m_skip = 0;
    m_restart = (prev == 1 && m_skip == 0) ? 1 : 0;
    if (bl)      m_bo = 1;
    else if (bh) m_bo = 0;
    if (!sb)               m_run = 0;
    else if (m_run < CONF) m_run = m_run + 1;
    compare_all();
  endtask

  // R9: switch returns mid-cycle, before any clock edge
  task automatic check_immediate_exit();
    @(negedge clk);
    stby = 1'b0;
    #0.5;
    check(pfc_en, 1'b1, "R9 immediate reconnect");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset state
    #12;
    check(skip_req, 1'b0, "R11 skip_req");
    check(ss_restart, 1'b0, "R11 ss_restart");
    check(ss_active, 1'b0, "R11 ss_active");
    check(inhibit, 1'b1, "R11 pulse_inhibit");
    check(pfc_en, 1'b0, "R11 pfc_sw_en");
    @(negedge clk); rst_n = 1'b1;
    // R5: brown-out stays until high flag, then clears
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,0);
    // R1/R2/R3/R4: skip entry, hold, release, ramp
    step(1,0,0,0,0,0,0);
    for (int i = 0; i < 4; i++) step(0,0,0,0,0,0,0);
    step(1,1,0,0,0,0,0);
    step(0,1,0,0,0,0,0);
    for (int i = 0; i < SS + 3; i++) step(0,0,0,0,0,0,0);
    // R4: second restart inside a running window reloads it
    step(1,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0);
    for (int i = 0; i < SS + 2; i++) step(0,0,0,0,0,0,0);
    // R8: standby spells one edge short, then drop
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < CONF - 1; i++) step(0,0,1,0,0,0,0);
      step(0,0,0,0,0,0,0);
    end
    // R7: full confirmation, then hold
    for (int i = 0; i < CONF + 5; i++) step(0,0,1,0,0,0,0);
    check(pfc_en, 1'b0, "R7 confirmed standby opens switch");
    check_immediate_exit();
    step(0,0,0,0,0,0,0);
    // R10: faults, latched faults, brown-out with both flags (low wins, R5)
    step(0,0,0,0,0,1,0);
    step(0,0,0,0,0,0,1);
    step(0,0,0,1,1,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0);
    // mixed pseudo-random traffic, all outputs compared every clock
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] r;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      r = lcg[22:16];
      step(r[0] & r[1], r[2], (lcg[27:24] != 4'd0), r[3] & r[4] & r[5],
           r[6], (lcg[30:28] == 3'd7), (lcg[12:8] == 5'd31));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule